// File: doc/BRIEF.md
# PHY Management Register File

This block models the management register space of an Ethernet PHY as seen by a MAC-side controller. It holds thirty-two 16-bit words, addressed by a 5-bit index through a single read/write port. Most words simply store what was last written. Three words are synthesized on every read. The status word and the diagnostic word depend on a link-up input. The link-partner word and the diagnostic word also derive from the modes held in the advertisement word (index 4).

The read data and a valid strobe appear one clock after the read request. A duplex-mismatch flag compares the full-duplex bit of the diagnostic word with a MAC duplex input. The flag is refreshed only on cycles where a MAC-enable input is high and holds its value otherwise. Serial management framing and real autonegotiation lie outside this block.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, index 0 reads 0x3100, index 2 reads 0x0300, index 3 reads 0xE400 and index 4 reads 0x01E1. All other stored indices read 0. At reset rdata_o, rvalid_o and dup_mismatch_o are 0.
- R2: rvalid_o is 1 in the cycle after a cycle with rd_en_i high and 0 otherwise. rdata_o keeps its value in cycles that follow no read.
- R3: A write stores wdata_i at index addr_i. A later read of any index other than 1, 5 or 18 returns the stored word.
- R4: A read of index 1 returns 0x782C while link_up_i is 1, and 0 while it is 0. The value 0x782C sets bits 14, 13, 12, 11, 5, 3 and 2.
- R5: A read of index 5 returns 0x4001 ORed with bits 8:5 of the index-4 word, whatever the state of the link.
- R6: A read of index 18 returns 0 while link_up_i is 0. With the link up, bit 10 is index-4 bit 7 OR index-4 bit 8.
- R7: With the link up, index 18 bit 11 is index-4 bit 8 OR index-4 bit 6. All other bits of index 18 are 0.
- R8: Writes to indices 1, 5 and 18 have no effect on what reads of those indices return.
- R9: In a cycle with mac_en_i high, dup_mismatch_o takes mac_full_dup_i XOR (index-18 bit 11) in the next cycle. In a cycle with mac_en_i low it holds its value.
- R10: A read issued in the same cycle as a write to the same index returns the contents from before the write. Computed words also use the index-4 word from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request for index addr_i |
| wr_en_i | input | 1 | Write request for index addr_i |
| addr_i | input | 5 | Register index shared by read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| rvalid_o | output | 1 | rdata_o carries the result of the previous cycle's read |
| link_up_i | input | 1 | Link state, 1 = up |
| mac_en_i | input | 1 | MAC enable; gates the mismatch flag update |
| mac_full_dup_i | input | 1 | MAC duplex setting, 1 = full |
| dup_mismatch_o | output | 1 | MAC and PHY duplex disagree |

## Verification
The properties assume that inputs are stable at each rising edge. They also assume that link_up_i during a read request is the level meant to gate the computed words of that read. The bench changes every input half a period away from the active edge, so each read sees a settled link level and a settled index. It reaches the mismatch flag by holding mac_en_i low while the duplex input moves, and by dropping the link so that the PHY side of the comparison is known to be 0.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_ID_HI = 2;
  localparam int unsigned IDX_ID_LO = 3;
  localparam int unsigned IDX_ADV   = 4;
  localparam int unsigned IDX_LPA   = 5;
  localparam int unsigned IDX_DIAG  = 18;

  // advertisement mode bits, relative to bit 5 of the index-4 word
  localparam int unsigned ADV_LSB   = 5;
  localparam int unsigned ADV_W     = 4;
  localparam int unsigned MODE_10F  = 1;
  localparam int unsigned MODE_100H = 2;
  localparam int unsigned MODE_100F = 3;

  localparam logic [15:0] STAT_UP_WORD = 16'h782C;
  localparam logic [15:0] LPA_FIXED    = 16'h4001;
  localparam int unsigned DIAG_SPD_BIT = 10;
  localparam int unsigned DIAG_DUP_BIT = 11;

  function automatic logic [15:0] reset_word(input int unsigned idx);
    case (idx)
      IDX_CTRL:  return 16'h3100;
      IDX_ID_HI: return 16'h0300;
      IDX_ID_LO: return 16'hE400;
      IDX_ADV:   return 16'h01E1;
      default:   return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  words_o
);
  import phy_mgmt_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam logic [DATA_W-1:0] RST = DATA_W'(reset_word(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_o[g] <= RST;
      else if (wr_en_i && (addr_i == ADDR_W'(g)))
        words_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/phy_reg_compute.sv
module phy_reg_compute #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [phy_mgmt_pkg::ADV_W-1:0] adv_modes_i,
  input  logic                           link_up_i,
  output logic [DATA_W-1:0]              stat_o,
  output logic [DATA_W-1:0]              lpa_o,
  output logic [DATA_W-1:0]              diag_o
);
  import phy_mgmt_pkg::*;

  logic spd_100, full_dup;

  always_comb begin
    spd_100  = adv_modes_i[MODE_100H] | adv_modes_i[MODE_100F];
    full_dup = adv_modes_i[MODE_100F] | adv_modes_i[MODE_10F];

    stat_o = link_up_i ? DATA_W'(STAT_UP_WORD) : '0;

    lpa_o = DATA_W'(LPA_FIXED);
    lpa_o[ADV_LSB +: ADV_W] = adv_modes_i;

    diag_o = '0;
    if (link_up_i) begin
      diag_o[DIAG_SPD_BIT] = spd_100;
      diag_o[DIAG_DUP_BIT] = full_dup;
    end
  end
endmodule

// File: rtl/phy_read_port.sv
module phy_read_port #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             rd_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  words_i,
  input  logic [DATA_W-1:0]                stat_i,
  input  logic [DATA_W-1:0]                lpa_i,
  input  logic [DATA_W-1:0]                diag_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             rvalid_o
);
  import phy_mgmt_pkg::*;

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    if (addr_i == ADDR_W'(IDX_STAT))      sel_word = stat_i;
    else if (addr_i == ADDR_W'(IDX_LPA))  sel_word = lpa_i;
    else if (addr_i == ADDR_W'(IDX_DIAG)) sel_word = diag_i;
    else                                  sel_word = words_i[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= sel_word;
    end
  end
endmodule

// File: rtl/phy_dup_monitor.sv
module phy_dup_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mac_en_i,
  input  logic mac_full_dup_i,
  input  logic phy_full_dup_i,
  output logic mismatch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mismatch_o <= 1'b0;
    else if (mac_en_i) mismatch_o <= mac_full_dup_i ^ phy_full_dup_i;
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              link_up_i,
  input  logic              mac_en_i,
  input  logic              mac_full_dup_i,
  output logic              dup_mismatch_o
);
  import phy_mgmt_pkg::*;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0] stat_w, lpa_w, diag_w;
  logic [ADV_W-1:0]  adv_modes;

  assign adv_modes = words[IDX_ADV][ADV_LSB +: ADV_W];

  phy_reg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .words_o (words)
  );

  phy_reg_compute #(.DATA_W(DATA_W)) u_compute (
    .adv_modes_i (adv_modes),
    .link_up_i   (link_up_i),
    .stat_o      (stat_w),
    .lpa_o       (lpa_w),
    .diag_o      (diag_w)
  );

  phy_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .words_i  (words),
    .stat_i   (stat_w),
    .lpa_i    (lpa_w),
    .diag_i   (diag_w),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  phy_dup_monitor u_dup (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mac_en_i       (mac_en_i),
    .mac_full_dup_i (mac_full_dup_i),
    .phy_full_dup_i (diag_w[DIAG_DUP_BIT]),
    .mismatch_o     (dup_mismatch_o)
  );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              link_up_i,
  input logic              mac_en_i,
  input logic              mac_full_dup_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              dup_mismatch_o
);
  logic rd_stat, rd_lpa, rd_diag;
  assign rd_stat = rd_en_i && (addr_i == ADDR_W'(1));
  assign rd_lpa  = rd_en_i && (addr_i == ADDR_W'(5));
  assign rd_diag = rd_en_i && (addr_i == ADDR_W'(18));

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R2
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R2
  AST_STAT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat && link_up_i |=> rdata_o == DATA_W'(16'h782C)); // R4
  AST_STAT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat && !link_up_i |=> rdata_o == '0); // R4
  AST_LPA_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lpa |=> (rdata_o & ~DATA_W'(16'h01E0)) == DATA_W'(16'h4001)); // R5
  AST_DIAG_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_diag && !link_up_i |=> rdata_o == '0); // R6
  AST_DIAG_SPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_diag |=> (rdata_o & ~DATA_W'(16'h0C00)) == '0); // R7
  AST_MM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mac_en_i |=> $stable(dup_mismatch_o)); // R9
  AST_MM_LINK_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_en_i && !link_up_i |=> dup_mismatch_o == $past(mac_full_dup_i)); // R9
endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/phy_mgmt_regfile_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rvalid_o;
  logic        link_up_i = 1'b1, mac_en_i = 1'b0, mac_full_dup_i = 1'b0;
  logic        dup_mismatch_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] adv_model = 16'h01E1;

  always #2 clk_i = ~clk_i;

  phy_mgmt_regfile dut_i (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_lpa(input logic [15:0] adv);
    return 16'h4001 | (adv & 16'h01E0);
  endfunction

  function automatic logic [15:0] exp_diag(input logic [15:0] adv, input logic lnk);
    logic [15:0] r = '0;
    if (lnk) begin
      r[10] = adv[7] | adv[8];
      r[11] = adv[8] | adv[6];
    end
    return r;
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a == 5'd4) adv_model = d;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 rdata_o", rdata_o, 16'h0);
    check("R1 rvalid_o", {15'b0, rvalid_o}, 16'h0);
    check("R1 dup_mismatch_o", {15'b0, dup_mismatch_o}, 16'h0);
    do_read(5'd0, d);  check("R1 idx0", d, 16'h3100);
    do_read(5'd2, d);  check("R1 idx2", d, 16'h0300);
    do_read(5'd3, d);  check("R1 idx3", d, 16'hE400);
    do_read(5'd4, d);  check("R1 idx4", d, 16'h01E1);
    do_read(5'd7, d);  check("R1 idx7", d, 16'h0);
    do_read(5'd31, d); check("R1 idx31", d, 16'h0);
  endtask

  task automatic t_latency();
    do_write(5'd9, 16'hBEEF);
    @(negedge clk_i);
    addr_i = 5'd9; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0; addr_i = 5'd0;
    check("R2 rvalid after read", {15'b0, rvalid_o}, 16'h1);
    check("R2 data after read", rdata_o, 16'hBEEF);
    @(negedge clk_i);
    check("R2 rvalid idle", {15'b0, rvalid_o}, 16'h0);
    check("R2 rdata held", rdata_o, 16'hBEEF);
  endtask

  task automatic t_store();
    logic [15:0] d;
    do_write(5'd7, 16'hA5A5);
    do_write(5'd31, 16'h1234);
    do_write(5'd0, 16'hFFFF);
    do_read(5'd7, d);  check("R3 idx7", d, 16'hA5A5);
    do_read(5'd31, d); check("R3 idx31", d, 16'h1234);
    do_read(5'd0, d);  check("R3 idx0", d, 16'hFFFF);
  endtask

  task automatic t_status();
    logic [15:0] d;
    link_up_i = 1'b1;
    do_read(5'd1, d); check("R4 link up", d, 16'h782C);
    link_up_i = 1'b0;
    do_read(5'd1, d); check("R4 link down", d, 16'h0);
    link_up_i = 1'b1;
  endtask

  task automatic t_lpa();
    logic [15:0] d;
    logic [15:0] pats [4] = '{16'h01E1, 16'h0000, 16'hFE1F, 16'h0140};
    foreach (pats[i]) begin
      do_write(5'd4, pats[i]);
      do_read(5'd5, d);
      check("R5 lpa", d, exp_lpa(pats[i]));
    end
    link_up_i = 1'b0;
    do_read(5'd5, d); check("R5 lpa link down", d, exp_lpa(adv_model));
    link_up_i = 1'b1;
  endtask

  task automatic t_diag();
    logic [15:0] d;
    logic [15:0] pats [5] = '{16'h0080, 16'h0100, 16'h0040, 16'h0020, 16'hFFFF};
    foreach (pats[i]) begin
      do_write(5'd4, pats[i]);
      do_read(5'd18, d);
      check("R6 R7 diag", d, exp_diag(pats[i], 1'b1));
    end
    link_up_i = 1'b0;
    do_read(5'd18, d); check("R6 diag link down", d, 16'h0);
    link_up_i = 1'b1;
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    do_write(5'd4, 16'h0040);
    do_write(5'd1, 16'h0000);
    do_write(5'd5, 16'hFFFF);
    do_write(5'd18, 16'hFFFF);
    do_read(5'd1, d);  check("R8 idx1", d, 16'h782C);
    do_read(5'd5, d);  check("R8 idx5", d, exp_lpa(16'h0040));
    do_read(5'd18, d); check("R8 idx18", d, exp_diag(16'h0040, 1'b1));
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    do_write(5'd4, 16'h0020);
    @(negedge clk_i);
    addr_i = 5'd4; wdata_i = 16'h0100; wr_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    adv_model = 16'h0100;
    check("R10 old value on collision", rdata_o, 16'h0020);
    do_read(5'd4, d);  check("R10 new value after", d, 16'h0100);
    do_read(5'd18, d); check("R10 diag from new", d, 16'h0C00);
  endtask

  task automatic t_mismatch();
    do_write(5'd4, 16'h01E1);
    link_up_i = 1'b1;
    @(negedge clk_i);
    mac_en_i = 1'b1; mac_full_dup_i = 1'b0;
    @(negedge clk_i);
    check("R9 half vs full", {15'b0, dup_mismatch_o}, 16'h1);
    mac_en_i = 1'b0; mac_full_dup_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 hold while disabled", {15'b0, dup_mismatch_o}, 16'h1);
    mac_en_i = 1'b1;
    @(negedge clk_i);
    check("R9 agree", {15'b0, dup_mismatch_o}, 16'h0);
    link_up_i = 1'b0;
    @(negedge clk_i);
    check("R9 link down", {15'b0, dup_mismatch_o}, 16'h1);
    mac_en_i = 1'b0; link_up_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_latency();
    t_store();
    t_status();
    t_lpa();
    t_diag();
    t_ignore();
    t_same_cycle();
    t_mismatch();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule